// File: doc/BRIEF.md
# Two-Wire Management Bus Register Target

This block is the target side of a two-wire management bus (SMBus 2.0 byte protocols). It watches the clock line (SCL) and data line (SDA) with the chip's own clock. It finds START, repeated START and STOP conditions and checks each address byte against a fixed 7-bit address. When it answers, it pulls SDA low through an active-high output-enable, which the pad turns into an open-drain driver. Behind the bus sits a plain register port: a pointer that doubles as the register address, a one-cycle write strobe, write data, and read data that the register bank returns combinationally for the current pointer.

Four byte protocols are decoded. Send Byte loads the pointer. Receive Byte reads the register the pointer selects. Write Byte loads the pointer and then writes one byte. Read Byte loads the pointer, turns the bus round with a repeated START and returns one byte. The block also answers the shared alert-response address while its alert flag is set, returning its own address. Traffic that does not fit these shapes goes unanswered and leaves the registers and the pointer as they were. For a configurable number of clock cycles after reset the block ignores the bus completely. No part of the logic depends on the SCL period, so another device may hold SCL low for as long as it wants.

Top module: `smb_target`

## Requirements
- R1: An address byte whose upper seven bits equal TGT_ADDR (default binary 1001100) is acknowledged by driving SDA low (sda_oe=1) during the ninth SCL high phase. Any other address, apart from the case in R5, is not acknowledged, the rest of the transaction is ignored, and neither reg_we nor reg_addr changes.
- R2: Write Byte (address with R/W bit 0, pointer byte, data byte) acknowledges all three bytes. It then issues exactly one single-cycle reg_we pulse, with reg_addr equal to the pointer byte and reg_wdata equal to the data byte, after the data byte's acknowledge clock.
- R3: Send Byte (address with R/W bit 0, one byte, STOP) sets reg_addr to that byte without writing. reg_addr changes only after the byte's acknowledge. A later Receive Byte (address with R/W bit 1) returns the register at reg_addr, most significant bit first.
- R4: Read Byte (address+W, pointer byte, repeated START, address+R) returns the register selected by the pointer byte. A host NACK followed by STOP ends the read.
- R5: While the alert flag is set (it is set by a rising edge of alert_i), a read to address 0001100 is acknowledged and returns TGT_ADDR in bits 7:1 with bit 0 = 0. The flag clears after that byte, so an immediately repeated alert-response read is not acknowledged.
- R6: With no alert pending, address 0001100 is not acknowledged, whatever its R/W bit.
- R7: For PWRUP_CYC clock cycles after reset, all bus traffic is ignored and sda_oe stays 0, even for the block's own address.
- R8: sda_oe changes only while the synchronized SCL is low, and it is released after every acknowledge and every transmitted byte. Operation is unaffected by an arbitrarily long SCL low phase.
- R9: A STOP or repeated START inside a byte discards that byte: no reg_we, and reg_addr keeps its value.
- R10: After the data byte of a Write Byte, further bytes are not acknowledged and cause no write.
- R11: After reset, sda_oe=0, reg_we=0 and reg_addr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| alert_i | input | 1 | Internal alert request; a rising edge sets the alert flag |
| reg_addr | output | 8 | Register pointer, used as the register address |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_wdata | output | 8 | Data for the write strobe |
| reg_rdata | input | 8 | Register contents at reg_addr |

## Verification
The hardest cases to reach from the ports are a byte cut short by STOP or a repeated START, and the alert-response reply. Both need exact bit-level control of the bus, not whole-byte transactions. The bench therefore drives SCL and SDA through a bit-level host model that can stop after any number of bits and insert conditions in the middle of a byte. It raises alert_i between transactions and then issues the alert-response read twice in a row. Around these cases it sweeps all 128 addresses with complete write attempts, reads back many pointer values through both read protocols, and repeats transfers with SCL held low for a long time.

// File: rtl/smb_pkg.sv
`timescale 1ns/1ps
package smb_pkg;
  localparam logic [6:0] ARA_ADDR = 7'b0001100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_CMD,
    ST_DATA,
    ST_TX,
    ST_TXACK,
    ST_WAIT
  } smb_state_e;

  typedef enum logic [1:0] {
    K_ADDRW,
    K_READ,
    K_CMD,
    K_DATA
  } smb_ack_e;
endpackage

// File: rtl/smb_sync.sv
`timescale 1ns/1ps
module smb_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], d[g]};
    end
    assign q[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/smb_events.sv
`timescale 1ns/1ps
module smb_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic cond_start,
  output logic cond_stop
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  always_comb begin
    scl_rise   = ~scl_p & scl_s;
    scl_fall   = scl_p & ~scl_s;
    cond_start = scl_p & scl_s & sda_p & ~sda_s;
    cond_stop  = scl_p & scl_s & ~sda_p & sda_s;
  end
endmodule

// File: rtl/smb_engine.sv
`timescale 1ns/1ps
module smb_engine
  import smb_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h4C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       cond_start,
  input  logic       cond_stop,
  input  logic       sda_lvl,
  input  logic       alert_i,
  input  logic [7:0] reg_rdata,
  output logic       sda_oe,
  output logic       reg_we,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata
);
  smb_state_e st_q, st_d;
  smb_ack_e   kind_q, kind_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] ptr_q, ptr_d;
  logic [7:0] wd_q, wd_d;
  logic       oe_q, oe_d;
  logic       ph_q, ph_d;
  logic       ara_q, ara_d;
  logic       pend_q, pend_d;
  logic       alq_q, alq_d;
  logic       we_q, we_d;
  logic [7:0] rx;

  assign rx = {sh_q[6:0], sda_lvl};

  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    ptr_d  = ptr_q;
    wd_d   = wd_q;
    oe_d   = oe_q;
    ph_d   = ph_q;
    ara_d  = ara_q;
    we_d   = 1'b0;
    alq_d  = alert_i;
    pend_d = pend_q | (alert_i & ~alq_q);
    if (!en) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (cond_start) begin
      st_d  = ST_ADDR;
      bit_d = 3'd0;
      oe_d  = 1'b0;
      ph_d  = 1'b0;
    end else if (cond_stop) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d  = rx;
            bit_d = bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              ph_d  = 1'b0;
              ara_d = 1'b0;
              if (rx[7:1] == TGT_ADDR) begin
                st_d   = ST_ACK;
                kind_d = rx[0] ? K_READ : K_ADDRW;
                if (rx[0]) sh_d = reg_rdata;
              end else if (rx == {ARA_ADDR, 1'b1} && pend_q) begin
                st_d   = ST_ACK;
                kind_d = K_READ;
                ara_d  = 1'b1;
                sh_d   = {TGT_ADDR, 1'b0};
              end else begin
                st_d = ST_WAIT;
              end
            end
          end
        end
        ST_CMD, ST_DATA: begin
          if (scl_rise) begin
            sh_d  = rx;
            bit_d = bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              st_d   = ST_ACK;
              ph_d   = 1'b0;
              kind_d = (st_q == ST_CMD) ? K_CMD : K_DATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (!ph_q) begin
              oe_d = 1'b1;
              ph_d = 1'b1;
            end else begin
              ph_d  = 1'b0;
              bit_d = 3'd0;
              oe_d  = 1'b0;
              case (kind_q)
                K_ADDRW: st_d = ST_CMD;
                K_CMD: begin
                  ptr_d = sh_q;
                  st_d  = ST_DATA;
                end
                K_DATA: begin
                  we_d = 1'b1;
                  wd_d = sh_q;
                  st_d = ST_WAIT;
                end
                default: begin
                  oe_d = ~sh_q[7];
                  st_d = ST_TX;
                end
              endcase
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_d = bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              st_d = ST_TXACK;
              ph_d = 1'b0;
            end
          end else if (scl_fall) begin
            oe_d = ~sh_q[6];
            sh_d = {sh_q[6:0], 1'b0};
          end
        end
        ST_TXACK: begin
          if (scl_fall && !ph_q) begin
            oe_d = 1'b0;
            ph_d = 1'b1;
          end else if (scl_rise && ph_q) begin
            ph_d = 1'b0;
            st_d = ST_WAIT;
            if (ara_q) pend_d = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= K_ADDRW;
      bit_q  <= 3'd0;
      sh_q   <= 8'd0;
      ptr_q  <= 8'd0;
      wd_q   <= 8'd0;
      oe_q   <= 1'b0;
      ph_q   <= 1'b0;
      ara_q  <= 1'b0;
      pend_q <= 1'b0;
      alq_q  <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      ptr_q  <= ptr_d;
      wd_q   <= wd_d;
      oe_q   <= oe_d;
      ph_q   <= ph_d;
      ara_q  <= ara_d;
      pend_q <= pend_d;
      alq_q  <= alq_d;
      we_q   <= we_d;
    end
  end

  assign sda_oe    = oe_q;
  assign reg_we    = we_q;
  assign reg_addr  = ptr_q;
  assign reg_wdata = wd_q;
endmodule

// File: rtl/smb_target.sv
`timescale 1ns/1ps
module smb_target
  import smb_pkg::*;
#(
  parameter logic [6:0]  TGT_ADDR    = 7'h4C,
  parameter int unsigned PWRUP_CYC   = 1500000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       alert_i,
  output logic [7:0] reg_addr,
  output logic       reg_we,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata
);
  localparam int unsigned CW = $clog2(PWRUP_CYC + 2);

  logic          rst_m, rst_s;
  logic [1:0]    lines;
  logic          scl_lvl, sda_lvl;
  logic          scl_rise, scl_fall, cond_start, cond_stop;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pwr_done, done_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  always_comb begin
    cnt_d  = cnt_q;
    done_d = pwr_done;
    if (!pwr_done) begin
      if (cnt_q == CW'(PWRUP_CYC)) done_d = 1'b1;
      else                         cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cnt_q    <= '0;
      pwr_done <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      pwr_done <= done_d;
    end
  end

  smb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_s),
    .d     ({scl_i, sda_i}),
    .q     (lines)
  );
  assign scl_lvl = lines[1];
  assign sda_lvl = lines[0];

  smb_events u_ev (
    .clk        (clk),
    .rst_n      (rst_s),
    .scl_s      (scl_lvl),
    .sda_s      (sda_lvl),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .cond_start (cond_start),
    .cond_stop  (cond_stop)
  );

  smb_engine #(.TGT_ADDR(TGT_ADDR)) u_eng (
    .clk        (clk),
    .rst_n      (rst_s),
    .en         (pwr_done),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .cond_start (cond_start),
    .cond_stop  (cond_stop),
    .sda_lvl    (sda_lvl),
    .alert_i    (alert_i),
    .reg_rdata  (reg_rdata),
    .sda_oe     (sda_oe),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata)
  );
endmodule

module smb_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_lvl,
  input logic       sda_oe,
  input logic       reg_we,
  input logic [7:0] reg_addr,
  input logic       pwr_done
);
  // R8: SDA drive only moves while SCL is low
  p_oe_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_lvl));

  // R2: write strobe lasts one cycle
  p_we_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R2: write issued on an SCL falling edge, after the acknowledge clock
  p_we_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !$past(scl_lvl));

  // R3: pointer only updates at the end of an acknowledge, SCL low
  p_ptr_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_addr) |-> !$past(scl_lvl));

  // R7: silent window keeps SDA released
  p_silent_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_done |-> !sda_oe);

  // R7: window never reopens
  p_window_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_done |=> pwr_done);
endmodule

bind smb_target smb_target_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_lvl  (scl_lvl),
  .sda_oe   (sda_oe),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .pwr_done (pwr_done)
);

// File: tb/smb_target_test.sv
`timescale 1ns/1ps
module smb_target_test;
  localparam int CLK_P = 10;
  localparam int PWR   = 300;
  localparam logic [6:0] ME  = 7'h4C;
  localparam logic [6:0] ARA = 7'h0C;

  logic       clk, rst_n, scl_m, sda_m, alert_i;
  logic       sda_i, sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  int lo_c = 6, hi_c = 6;
  int nchk = 0, nfail = 0, we_cnt = 0;
  logic done = 1'b0;

  assign sda_i = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  smb_target #(.TGT_ADDR(ME), .PWRUP_CYC(PWR)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_i), .sda_oe(sda_oe),
    .alert_i(alert_i), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) if (reg_we) begin
    mem[reg_addr] <= reg_wdata;
    we_cnt <= we_cnt + 1;
  end

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 29 + 7) & 255);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic b_start;
    sda_m = 1'b0; tick(hi_c);
    scl_m = 1'b0; tick(1);
  endtask

  task automatic b_stop;
    sda_m = 1'b0; tick(lo_c);
    scl_m = 1'b1; tick(hi_c);
    sda_m = 1'b1; tick(hi_c);
  endtask

  task automatic b_rstart;
    sda_m = 1'b1; tick(lo_c);
    scl_m = 1'b1; tick(hi_c);
    sda_m = 1'b0; tick(hi_c);
    scl_m = 1'b0; tick(1);
  endtask

  task automatic b_bit(input logic b);
    sda_m = b; tick(lo_c);
    scl_m = 1'b1; tick(hi_c);
    scl_m = 1'b0; tick(1);
  endtask

  task automatic b_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) b_bit(b[7-i]);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    b_bits(b, 8);
    sda_m = 1'b1; tick(lo_c);
    scl_m = 1'b1; tick(hi_c/2);
    ack = ~sda_i; tick(hi_c - hi_c/2);
    scl_m = 1'b0; tick(1);
  endtask

  task automatic rbyte(output logic [7:0] d);
    d = 8'd0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(lo_c);
      scl_m = 1'b1; tick(hi_c/2);
      d = {d[6:0], sda_i}; tick(hi_c - hi_c/2);
      scl_m = 1'b0; tick(1);
    end
    b_bit(1'b1);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d,
                          output logic [2:0] acks);
    b_start;
    wbyte({a, 1'b0}, acks[2]);
    wbyte(p, acks[1]);
    wbyte(d, acks[0]);
    b_stop;
  endtask

  task automatic do_readbyte(input logic [7:0] p, output logic [7:0] d, output logic [2:0] acks);
    b_start;
    wbyte({ME, 1'b0}, acks[2]);
    wbyte(p, acks[1]);
    b_rstart;
    wbyte({ME, 1'b1}, acks[0]);
    rbyte(d);
    b_stop;
  endtask

  task automatic do_send(input logic [7:0] p, output logic [1:0] acks);
    b_start;
    wbyte({ME, 1'b0}, acks[1]);
    wbyte(p, acks[0]);
    b_stop;
  endtask

  task automatic do_recv(input logic [6:0] a, output logic [7:0] d, output logic ack);
    b_start;
    wbyte({a, 1'b1}, ack);
    if (ack) rbyte(d);
    else d = 8'hFF;
    b_stop;
  endtask

  initial begin
    logic       a1;
    logic [1:0] a2;
    logic [2:0] a3;
    logic [7:0] d;
    int         w0;
    logic [7:0] p0;
    for (int i = 0; i < 256; i++) mem[i] = init_val(i);
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; alert_i = 1'b0;
    tick(5);
    chk("R11 sda_oe after reset", int'(sda_oe), 0);
    chk("R11 reg_we after reset", int'(reg_we), 0);
    chk("R11 reg_addr after reset", int'(reg_addr), 0);
    rst_n = 1'b1;
    tick(2);

    // R7: own address inside the silent window
    b_start;
    wbyte({ME, 1'b0}, a1);
    b_stop;
    chk("R7 no ack in silent window", int'(a1), 0);
    tick(PWR + 20);

    // R6: alert-response read without pending alert
    do_recv(ARA, d, a1);
    chk("R6 ARA read nack", int'(a1), 0);
    b_start; wbyte({ARA, 1'b0}, a1); b_stop;
    chk("R6 ARA write nack", int'(a1), 0);

    // R2: write sweep
    for (int k = 0; k < 16; k++) begin
      logic [7:0] p, v;
      p = 8'(k * 16 + 3);
      v = 8'((k * 7) ^ 8'h3C);
      w0 = we_cnt;
      do_write(ME, p, v, a3);
      chk("R2 write acks", int'(a3), 7);
      chk("R2 one strobe", we_cnt - w0, 1);
      chk("R2 written value", int'(mem[p]), int'(v));
      mem[p] = init_val(p);
    end

    // R3: send byte then receive byte
    for (int k = 0; k < 16; k++) begin
      logic [7:0] p;
      p = 8'(k * 13 + 1);
      w0 = we_cnt;
      do_send(p, a2);
      chk("R3 send acks", int'(a2), 3);
      chk("R3 pointer loaded", int'(reg_addr), int'(p));
      chk("R3 send writes nothing", we_cnt - w0, 0);
      do_recv(ME, d, a1);
      chk("R3 receive ack", int'(a1), 1);
      chk("R3 receive data", int'(d), int'(init_val(p)));
    end

    // R4: read byte sweep
    for (int k = 0; k < 32; k++) begin
      logic [7:0] p;
      p = 8'(k * 8 + 5);
      do_readbyte(p, d, a3);
      chk("R4 read acks", int'(a3), 7);
      chk("R4 read data", int'(d), int'(init_val(p)));
    end

    // R1: address sweep
    p0 = reg_addr;
    w0 = we_cnt;
    for (int a = 0; a < 128; a++) begin
      if (7'(a) == ME) begin
        b_start; wbyte({ME, 1'b0}, a1); b_stop;
        chk("R1 own address ack", int'(a1), 1);
      end else begin
        do_write(7'(a), 8'h77, 8'hEE, a3);
        chk("R1 foreign address nack", int'(a3), 0);
      end
    end
    chk("R1 no write from foreign", we_cnt - w0, 0);
    chk("R1 pointer kept", int'(reg_addr), int'(p0));
    chk("R1 register untouched", int'(mem[8'h77]), int'(init_val(8'h77)));

    // R9: STOP inside pointer byte
    do_send(8'h20, a2);
    b_start; wbyte({ME, 1'b0}, a1); b_bits(8'h55, 4); b_stop;
    chk("R9 pointer kept after cut byte", int'(reg_addr), 8'h20);
    // R9: repeated START inside data byte
    w0 = we_cnt;
    b_start; wbyte({ME, 1'b0}, a1); wbyte(8'h33, a1); b_bits(8'hC3, 5);
    b_rstart; wbyte({ME, 1'b0}, a1); b_stop;
    chk("R9 no write after cut data", we_cnt - w0, 0);
    chk("R9 register untouched", int'(mem[8'h33]), int'(init_val(8'h33)));
    b_start; wbyte({ME, 1'b0}, a1); wbyte(8'h44, a1); b_bits(8'h0F, 3); b_stop;
    chk("R9 stop in data no write", we_cnt - w0, 0);

    // R10: extra byte after write data
    w0 = we_cnt;
    b_start; wbyte({ME, 1'b0}, a1); wbyte(8'h50, a1); wbyte(8'hA1, a1);
    chk("R10 data ack", int'(a1), 1);
    wbyte(8'h5A, a1);
    b_stop;
    chk("R10 extra byte nack", int'(a1), 0);
    chk("R10 single write", we_cnt - w0, 1);
    chk("R10 value", int'(mem[8'h50]), 8'hA1);
    mem[8'h50] = init_val(8'h50);

    // R8: long SCL low phases
    lo_c = 150;
    do_readbyte(8'h09, d, a3);
    chk("R8 stretched read acks", int'(a3), 7);
    chk("R8 stretched read data", int'(d), int'(init_val(8'h09)));
    do_write(ME, 8'h0A, 8'h96, a3);
    chk("R8 stretched write", int'(mem[8'h0A]), 8'h96);
    lo_c = 6;

    // R5: alert response
    alert_i = 1'b1; tick(4); alert_i = 1'b0; tick(4);
    do_recv(ARA, d, a1);
    chk("R5 ARA ack", int'(a1), 1);
    chk("R5 ARA returns own address", int'(d), int'({ME, 1'b0}));
    do_recv(ARA, d, a1);
    chk("R5 ARA cleared", int'(a1), 0);
    chk("R11 bus released at end", int'(sda_oe), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule